// File: doc/BRIEF.md
# Multichannel Stream Checker with Statistics

This block terminates a multichannel packet stream. It accepts beats that carry a channel number, start and end markers, an error field and a one-bit mismatch flag. The mismatch flag comes from an external data comparator. The block checks that every channel frames its packets correctly. It records the first exception it sees, and it keeps saturating per-channel counts of packets, symbols and data errors.

Software controls the block through a word-addressed register file with eight 32-bit locations. The stream ready signal is throttled: on each cycle, a free-running pseudo-random value is compared with a programmed rate, so a chosen share of cycles can accept data. Software reaches a channel's statistics by writing its number into a select register and then reading two count registers.

The register read path is combinational. The exception descriptor is cleared by the same read cycle that returns its value.

Top module: `stream_stat_checker`

## Requirements
- R1: Address 0 reads a constant identification word. Bits [15:0] hold 0x0065, [23:16] the channel count, [30:24] the symbols per beat, and bit 31 is 1 (packets supported). With the defaults the word is 0x84040065.
- R2: Address 1 holds the control fields: run enable in bit 0, rate in [16:8] and soft clear in bit 17. It reads back what was written, except that a rate above 256 is stored as 256. Its other bits read 0.
- R3: A 16-bit LFSR starts at 0xACE1 in reset and shifts left every cycle. The new bit 0 is the XOR of bits 15, 13, 12 and 10. When running, ready is high exactly when the LFSR's low byte is below the rate. A rate of 0 never accepts, and 256 accepts on every cycle.
- R4: Ready stays low while the run enable is 0 or the soft clear is 1.
- R5: An accepted beat without start-of-packet, on a channel that is not inside a packet, raises a missing-start exception (descriptor bit 1). The beat then opens a packet unless it carries end-of-packet.
- R6: An accepted start-of-packet beat on a channel that is already inside a packet raises a missing-end exception (descriptor bit 2).
- R7: Address 5 holds only the first exception since it was last clear. A read of address 5 clears it. It reads 0 when nothing is pending.
- R8: The descriptor sets bit 0 when the mismatch input is high, holds the beat's error field in [15:8] and its channel in [31:24]. A nonzero error field alone also counts as an exception.
- R9: Per channel, the packet count goes up by one for each accepted end-of-packet beat, and the symbol count goes up by the symbols per beat for each accepted beat. Address 7 returns the selected channel's symbol count in [31:16] and its packet count in [15:0].
- R10: Address 6 stores a channel select in [7:0]. Bits [31:16] read the selected channel's count of accepted beats that had mismatch high.
- R11: All counters stop at 0xFFFF and never wrap.
- R12: While the soft clear is 1, the counters, the packet framing state and the descriptor are held at zero.
- R13: Addresses 2, 3 and 4 read 0, and writes to them change nothing. A select at or above the channel count reads all counts as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 3 | Register word address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd | input | 1 | Register read strobe (clears the descriptor at address 5) |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat ready (throttled) |
| s_sop | input | 1 | Start-of-packet marker |
| s_eop | input | 1 | End-of-packet marker |
| s_channel | input | CH_W | Channel of the beat |
| s_error | input | ERR_W | Error field carried with the beat |
| s_mismatch | input | 1 | External comparator reports a data mismatch |

## Verification
On every cycle the assertions check the ready gating: never high when stopped or held, always high at full rate. They also check that counters never fall except under soft clear, that a pending descriptor stays stable until it is read or cleared, and that an exception is captured when nothing is pending. The exact ready pattern at intermediate rates, the bit positions of every register field, the indirect channel readback and the framing outcomes of a sequence of beats can only be shown by the bench's scenarios. The bench compares these against its own LFSR model and its arithmetic expectations.

// File: rtl/chk_pkg.sv
// Shared constants and types for the stream statistics checker.
// Assumes a 3-bit word address space of 32-bit registers.
package chk_pkg;
    localparam logic [15:0] CHK_ID    = 16'h0065;
    localparam int          THR_W     = 9;
    localparam logic [8:0]  THR_FULL  = 9'd256;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [2:0] {
        ADR_STATUS = 3'd0,
        ADR_CTRL   = 3'd1,
        ADR_EXC    = 3'd5,
        ADR_SEL    = 3'd6,
        ADR_CNT    = 3'd7
    } cfg_adr_e;

    typedef struct packed {
        logic [7:0] chan;
        logic [7:0] pad_hi;
        logic [7:0] err;
        logic [4:0] pad_lo;
        logic       miss_end;
        logic       miss_start;
        logic       data_bad;
    } exc_word_t;
endpackage

// File: rtl/chk_throttle.sv
// Rate gate: a free-running 16-bit maximal LFSR whose low byte is compared
// with a 0..256 rate to decide ready. Assumes rate is already clamped to 256.
module chk_throttle
    import chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [THR_W-1:0] rate,
    output logic             ready
);
    logic [15:0] lfsr_q;
    logic        fb;

    // feedback taps for the maximal 16-bit polynomial
    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // advance the pseudo-random sequence on every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= {lfsr_q[14:0], fb};
    end

    // accept when the random byte falls below the rate
    assign ready = run && ({1'b0, lfsr_q[7:0]} < rate);

    assert_rate_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |-> !ready);
    assert_rate_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rate == THR_FULL) |-> ready);
    assert_lfsr_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/chk_chan_stats.sv
// One channel's framing tracker and saturating statistics counters.
// Assumes beat is already qualified by accept and channel match.
module chk_chan_stats #(
    parameter int CNT_W        = 16,
    parameter int SYM_PER_BEAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             beat,
    input  logic             sop,
    input  logic             eop,
    input  logic             mismatch,
    output logic             miss_sop,
    output logic             miss_eop,
    output logic [CNT_W-1:0] pkt_cnt,
    output logic [CNT_W-1:0] sym_cnt,
    output logic [CNT_W-1:0] err_cnt
);
    localparam logic [CNT_W:0]   CNT_MAX = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0]   SYM_INC = (CNT_W+1)'(SYM_PER_BEAT);

    logic             in_pkt;
    logic [CNT_W:0]   sym_sum;

    // framing violations seen on the current beat
    assign miss_sop = beat && !sop && !in_pkt;
    assign miss_eop = beat &&  sop &&  in_pkt;

    // track whether the channel is inside a packet
    always_ff @(posedge clk) begin
        if (!rst_n)    in_pkt <= 1'b0;
        else if (clr)  in_pkt <= 1'b0;
        else if (beat) in_pkt <= !eop;
    end

    // widened sum used to saturate the symbol count
    assign sym_sum = {1'b0, sym_cnt} + SYM_INC;

    // saturating packet, symbol and error counters
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pkt_cnt <= '0;
            sym_cnt <= '0;
            err_cnt <= '0;
        end else if (beat) begin
            if (eop && pkt_cnt != '1)      pkt_cnt <= pkt_cnt + 1'b1;
            if (mismatch && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
            sym_cnt <= (sym_sum > CNT_MAX) ? '1 : sym_sum[CNT_W-1:0];
        end
    end

    assert_no_wrap_pkt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> pkt_cnt >= $past(pkt_cnt));
    assert_no_wrap_sym_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> sym_cnt >= $past(sym_cnt));
    assert_no_wrap_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> err_cnt >= $past(err_cnt));
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pkt_cnt == '0 && sym_cnt == '0 && err_cnt == '0));
    assert_frame_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_sop && miss_eop));
endmodule

// File: rtl/chk_exc_capture.sv
// First-exception holder: loads a descriptor when empty, keeps it until a
// read of the descriptor or a soft clear. A read in the same cycle as a new
// exception loads the new one.
module chk_exc_capture
    import chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        rd_clr,
    input  logic        ev,
    input  exc_word_t   ev_word,
    output logic [31:0] desc
);
    logic pending;

    assign pending = (desc != '0);

    // capture, hold and clear the first exception
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              desc <= '0;
        else if (ev && (!pending || rd_clr)) desc <= ev_word;
        else if (rd_clr)                desc <= '0;
    end

    assert_hold_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rd_clr && !clr) |=> $stable(desc));
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !pending && !clr) |=> desc != '0);
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev) |=> desc == '0);
endmodule

// File: rtl/stream_stat_checker.sv
// Multichannel stream sink with a register file, throttled ready, framing
// checks, first-exception capture and indirect per-channel statistics.
// Assumes NUM_CH in 2..256, ERR_W <= 8, CNT_W <= 16, and beats that never
// mark two channels at once.
module stream_stat_checker
    import chk_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int SYM_PER_BEAT = 4,
    parameter int CNT_W        = 16,
    parameter int ERR_W        = 8,
    parameter int CH_W         = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_addr,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_rd,
    output logic [31:0]      cfg_rdata,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic             s_sop,
    input  logic             s_eop,
    input  logic [CH_W-1:0]  s_channel,
    input  logic [ERR_W-1:0] s_error,
    input  logic             s_mismatch
);
    localparam logic [31:0] STATUS_WORD =
        {1'b1, 7'(SYM_PER_BEAT), 8'(NUM_CH), CHK_ID};

    logic             run_en;
    logic             soft_clr;
    logic [THR_W-1:0] rate;
    logic [7:0]       sel;
    logic             accept;
    logic             rd_clr;
    logic             ev;
    exc_word_t        ev_word;
    logic [31:0]      desc;
    logic [NUM_CH-1:0] miss_sop_v, miss_eop_v;
    logic [CNT_W-1:0] pkt_a [NUM_CH];
    logic [CNT_W-1:0] sym_a [NUM_CH];
    logic [CNT_W-1:0] err_a [NUM_CH];
    logic             sel_ok;
    logic [CNT_W-1:0] pkt_sel, sym_sel, err_sel;

    // control and select registers, rate clamped to the full value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            soft_clr <= 1'b0;
            rate     <= '0;
            sel      <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                ADR_CTRL: begin
                    run_en   <= cfg_wdata[0];
                    soft_clr <= cfg_wdata[17];
                    rate     <= (cfg_wdata[16:8] > THR_FULL) ? THR_FULL : cfg_wdata[16:8];
                end
                ADR_SEL: sel <= cfg_wdata[7:0];
                default: ;
            endcase
        end
    end

    chk_throttle u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en && !soft_clr),
        .rate  (rate),
        .ready (s_ready)
    );

    assign accept = s_valid && s_ready;

    // one framing tracker and counter set per channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chk_chan_stats #(
            .CNT_W        (CNT_W),
            .SYM_PER_BEAT (SYM_PER_BEAT)
        ) u_stats (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (soft_clr),
            .beat     (accept && (s_channel == CH_W'(i))),
            .sop      (s_sop),
            .eop      (s_eop),
            .mismatch (s_mismatch),
            .miss_sop (miss_sop_v[i]),
            .miss_eop (miss_eop_v[i]),
            .pkt_cnt  (pkt_a[i]),
            .sym_cnt  (sym_a[i]),
            .err_cnt  (err_a[i])
        );
    end

    // assemble the exception event of the current beat
    always_comb begin
        ev_word            = '0;
        ev_word.chan       = 8'(s_channel);
        ev_word.err        = 8'(s_error);
        ev_word.miss_end   = |miss_eop_v;
        ev_word.miss_start = |miss_sop_v;
        ev_word.data_bad   = s_mismatch;
        ev = accept && (s_mismatch || (|miss_sop_v) || (|miss_eop_v) || (|s_error));
    end

    assign rd_clr = cfg_rd && (cfg_addr == ADR_EXC);

    chk_exc_capture u_exc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .rd_clr  (rd_clr),
        .ev      (ev),
        .ev_word (ev_word),
        .desc    (desc)
    );

    // pick the selected channel's counters, zero when out of range
    always_comb begin
        sel_ok  = (32'(sel) < NUM_CH);
        pkt_sel = sel_ok ? pkt_a[sel[CH_W-1:0]] : '0;
        sym_sel = sel_ok ? sym_a[sel[CH_W-1:0]] : '0;
        err_sel = sel_ok ? err_a[sel[CH_W-1:0]] : '0;
    end

    // register read multiplexer
    always_comb begin
        case (cfg_addr)
            ADR_STATUS: cfg_rdata = STATUS_WORD;
            ADR_CTRL:   cfg_rdata = {14'd0, soft_clr, rate, 7'd0, run_en};
            ADR_EXC:    cfg_rdata = desc;
            ADR_SEL:    cfg_rdata = {16'(err_sel), 8'd0, sel};
            ADR_CNT:    cfg_rdata = {16'(sym_sel), 16'(pkt_sel)};
            default:    cfg_rdata = '0;
        endcase
    end

    assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || soft_clr) |-> !s_ready);
    assert_rate_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rate <= THR_FULL);
    assert_soft_desc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> desc == '0);
endmodule

// File: tb/stream_stat_checker_test.sv
// Self-checking bench: rate sweeps against an LFSR model, framing and
// exception sequences, indirect readback, soft clear and saturation.
module stream_stat_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CHW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_rdata;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        s_sop = 1'b0;
    logic        s_eop = 1'b0;
    logic [CHW-1:0] s_channel = '0;
    logic [7:0]  s_error = '0;
    logic        s_mismatch = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_lfsr;

    stream_stat_checker uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .s_valid(s_valid), .s_ready(s_ready), .s_sop(s_sop), .s_eop(s_eop),
        .s_channel(s_channel), .s_error(s_error), .s_mismatch(s_mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference sequence taken from the R3 definition
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic beat(input int ch, input logic sop, input logic eop,
                        input logic mm, input logic [7:0] err);
        @(negedge clk);
        s_valid = 1'b1; s_channel = CHW'(ch); s_sop = sop; s_eop = eop;
        s_mismatch = mm; s_error = err;
        @(negedge clk);
        s_valid = 1'b0; s_mismatch = 1'b0; s_error = '0;
    endtask

    task automatic send_pkt(input int ch, input int len);
        for (int i = 0; i < len; i++)
            beat(ch, i == 0, i == len - 1, 1'b0, 8'h00);
    endtask

    task automatic sweep(input int thr);
        int bad = 0;
        int eff = (thr > 256) ? 256 : thr;
        wr(3'd1, (32'(thr) << 8) | 32'd1);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); #1;
            if (s_ready !== ({23'd0, m_lfsr[7:0]} < 32'(eff))) bad++;
        end
        chk($sformatf("R3 ready pattern rate %0d", thr), 32'(bad), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R4 ready low after reset", 32'(s_ready), 32'd0);
        rd(3'd0, d); chk("R1 status word", d, 32'h84040065);
        rd(3'd1, d); chk("R2 control reset", d, 32'h0);
        rd(3'd5, d); chk("R7 descriptor empty", d, 32'h0);
        rd(3'd7, d); chk("R9 counts reset", d, 32'h0);

        // R2 readback, clamp, reserved bits
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R2 clamp and reserved", d, 32'h0003_0001);
        wr(3'd1, 32'h0000_C801);
        rd(3'd1, d); chk("R2 rate 200", d, 32'h0000_C801);

        // R13 reserved offsets and out-of-range select
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R13 offset 3", d, 32'h0);
        rd(3'd2, d); chk("R13 offset 2", d, 32'h0);
        rd(3'd4, d); chk("R13 offset 4", d, 32'h0);
        rd(3'd1, d); chk("R13 control untouched", d, 32'h0000_C801);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, d); chk("R13 select out of range", d, 32'h0000_00FF);
        rd(3'd7, d); chk("R13 counts out of range", d, 32'h0);

        // R3 rate sweep
        sweep(0); sweep(1); sweep(37); sweep(128);
        sweep(255); sweep(256); sweep(511);

        // R4 disabled and held
        wr(3'd1, 32'h0001_0000);
        bad = 0;
        for (int k = 0; k < 50; k++) begin @(negedge clk); #1; if (s_ready !== 1'b0) bad++; end
        chk("R4 ready low when disabled", 32'(bad), 32'd0);
        wr(3'd1, 32'h0003_0001);
        bad = 0;
        for (int k = 0; k < 50; k++) begin @(negedge clk); #1; if (s_ready !== 1'b0) bad++; end
        chk("R4 ready low under soft clear", 32'(bad), 32'd0);

        // R9 clean packets
        wr(3'd1, 32'h0001_0001);
        send_pkt(1, 3); send_pkt(1, 5); send_pkt(2, 1);
        wr(3'd6, 32'd1); rd(3'd7, d); chk("R9 ch1 counts", d, 32'h0020_0002);
        wr(3'd6, 32'd2); rd(3'd7, d); chk("R9 ch2 counts", d, 32'h0004_0001);
        rd(3'd5, d); chk("R5 no exception on clean framing", d, 32'h0);

        // R5 missing start, R7 read clears
        beat(3, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(3'd5, d); chk("R5 missing start ch3", d, 32'h0300_0002);
        rd(3'd5, d); chk("R7 read cleared", d, 32'h0);
        // R6 missing end, then R7 first only
        beat(3, 1'b1, 1'b0, 1'b0, 8'h00);
        beat(0, 1'b1, 1'b1, 1'b1, 8'h5A);
        rd(3'd5, d); chk("R6 R7 first exception kept", d, 32'h0300_0004);
        rd(3'd5, d); chk("R7 empty after read", d, 32'h0);
        beat(3, 1'b0, 1'b1, 1'b0, 8'h00);
        rd(3'd5, d); chk("R5 end inside packet is clean", d, 32'h0);
        wr(3'd6, 32'd3); rd(3'd7, d); chk("R5 R6 ch3 framing counts", d, 32'h000C_0001);

        // R8 fields
        beat(2, 1'b1, 1'b1, 1'b1, 8'hA5);
        rd(3'd5, d); chk("R8 descriptor fields", d, 32'h0200_A501);
        beat(1, 1'b1, 1'b1, 1'b0, 8'h3C);
        rd(3'd5, d); chk("R8 error field alone", d, 32'h0100_3C00);
        wr(3'd6, 32'd0); rd(3'd6, d); chk("R10 ch0 error count", d, 32'h0001_0000);
        wr(3'd6, 32'd2); rd(3'd6, d); chk("R10 ch2 error count", d, 32'h0001_0002);

        // R12 soft clear
        beat(1, 1'b1, 1'b0, 1'b1, 8'h00);
        wr(3'd1, 32'h0003_0001);
        #1 chk("R12 ready low in clear", 32'(s_ready), 32'd0);
        wr(3'd1, 32'h0001_0001);
        rd(3'd5, d); chk("R12 descriptor cleared", d, 32'h0);
        wr(3'd6, 32'd1); rd(3'd7, d); chk("R12 counts cleared", d, 32'h0);
        rd(3'd6, d); chk("R12 error count cleared", d, 32'h0000_0001);
        beat(1, 1'b1, 1'b1, 1'b0, 8'h00);
        rd(3'd5, d); chk("R12 framing state cleared", d, 32'h0);

        // R11 saturation
        @(negedge clk);
        s_valid = 1'b1; s_channel = 2'd2; s_sop = 1'b1; s_eop = 1'b1; s_mismatch = 1'b1;
        repeat (65540) @(negedge clk);
        s_valid = 1'b0; s_mismatch = 1'b0;
        wr(3'd6, 32'd2);
        rd(3'd6, d); chk("R11 error count saturates", d, 32'hFFFF_0002);
        rd(3'd7, d); chk("R11 packet and symbol saturate", d, 32'hFFFF_FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule